// File: doc/BRIEF.md
# Receive Descriptor Chain Writer

This block sits between the receive side of an Ethernet MAC and system memory. Incoming frames arrive as a byte stream with an end-of-frame mark. For every frame the block reads the current receive descriptor, a four-word record holding a status/length word, a buffer pointer, an unused word and a link to the next record. If the MAC owns that record, the frame's bytes are packed into little-endian 32-bit words and written to the buffer. The status word is then rewritten with the completion flags, the received length and CPU ownership, and the block moves on to the linked record.

If the MAC does not own the record, the frame is consumed and discarded. A one-cycle unavailable event fires, a saturating missed-frame counter increments, and the chain pointer stays put, so the same record is retried on the next frame. While reception is off the stream is not accepted and the chain pointer follows the configured list start. Frames longer than the standard maximum are flagged. In long-frame mode they are kept whole. Otherwise storage stops at the maximum and the frame is reported as not good.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset `in_ready` is low, `mem_req` is low, `miss_count` is 0, `ev_done` and `ev_unavail` are low, and `cur_desc` equals `list_start`.
- R2: The payload of a frame received into an owned record is written to consecutive words from the record's buffer pointer (record word offset 4). Byte n goes to bits 8*(n mod 4)+7:8*(n mod 4) of word n/4. Unused upper bytes of a final partial word are zero, and no word past the frame's last word is written.
- R3: On completion the status word (record offset 0) is rewritten with bits 31:30 = 00 (CPU-owned), bit 20 (good) set for a frame not truncated, bits 29:21 zero, and bits 15:0 = received byte count + 4.
- R4: Status bit 16 is set in the written-back status word exactly when `irq_en` is high at completion.
- R5: After a frame completes in a record, `cur_desc` takes the value of that record's next-record word (offset 12).
- R6: A record whose bits 31:30 are anything but binary 10 (MAC-owned) causes the whole frame to be accepted and discarded. It also causes one `ev_unavail` pulse and a `miss_count` increment, and it causes no memory write and no change of `cur_desc`.
- R7: While `rx_en` is low and no frame is in progress, `in_ready` and `mem_req` stay low and `cur_desc` follows `list_start`.
- R8: With `long_ok` high, a frame longer than `MAX_FRAME` bytes is stored whole, and its status has both bit 19 (too long) and bit 20 set.
- R9: With `long_ok` low, a frame longer than `MAX_FRAME` has only its first `MAX_FRAME` bytes stored and nothing after them. Its status has bit 19 set, bit 20 clear and the full received count + 4 as length.
- R10: A frame of exactly `MAX_FRAME` bytes is not flagged too long (bit 19 clear, bit 20 set).
- R11: `ev_done` pulses for exactly one cycle per completed frame, in the cycle the status word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Reception enable |
| long_ok | input | 1 | Keep frames longer than MAX_FRAME whole |
| irq_en | input | 1 | Set the interrupt flag (bit 16) in written-back status |
| list_start | input | ADDR_W | Address of the first record, loaded while reception is off |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (data returns the next cycle) |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cur_desc | output | ADDR_W | Address of the current record |
| ev_done | output | 1 | Frame completion pulse |
| ev_unavail | output | 1 | CPU-owned record met |
| miss_count | output | MISS_W | Saturating count of dropped frames |

## Verification
The last byte of a frame is taken at one clock edge. The status write, the `cur_desc` update and the `ev_done` pulse all belong to the next cycle, so they are visible after the second following edge. A dropped frame updates `miss_count` on the same edge that takes its last byte. The bench drives and samples on falling edges and waits two falling edges after a frame's last byte before comparing memory and `cur_desc`. One-cycle pulses and memory writes are counted by a falling-edge monitor and checked as differences over each scenario.

// File: rtl/rxdw_pkg.sv
// Shared types and status-word layout for the receive descriptor chain writer.
// Assumes 32-bit memory words and a four-word record.
package rxdw_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RD_ST, S_RD_BUF, S_RD_NXT, S_CHK, S_DATA, S_DROP, S_WB
    } rx_state_t;

    localparam int          WORD_W    = 32;
    localparam logic [1:0]  OWNER_MAC = 2'b10;
    localparam int          BIT_GOOD  = 20;
    localparam int          BIT_LONG  = 19;
    localparam int          BIT_IRQ   = 16;

    // Build the written-back status word: CPU ownership, flags, length.
    function automatic logic [WORD_W-1:0] make_status(input logic good, input logic too_long,
                                                      input logic irq, input logic [15:0] len);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_GOOD] = good;
        w[BIT_LONG] = too_long;
        w[BIT_IRQ]  = irq;
        w[15:0]     = len;
        return w;
    endfunction
endpackage

// File: rtl/rxdw_packer.sv
// Byte-to-word packer and length counter for one frame.
// Packs bytes little-endian, counts every byte, stops storing at MAX_FRAME
// unless long frames are kept. Assumes clr is high between frames.
module rxdw_packer #(
    parameter int MAX_FRAME = 1518,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_fire,
    input  logic [7:0]       byte_in,
    input  logic             last_in,
    input  logic             long_ok,
    output logic             wr_fire,
    output logic [31:0]      wr_word,
    output logic [LEN_W-1:0] wr_off,
    output logic [LEN_W-1:0] len,
    output logic             too_long
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);

    logic [LEN_W-1:0] len_q;
    logic [31:0]      acc_q;
    logic             store;
    logic             word_end;

    // Decide whether this byte is stored and whether it closes a word.
    always_comb begin
        store    = long_ok || (len_q < MAX_L);
        word_end = (len_q[1:0] == 2'd3) || last_in || (!long_ok && len_q == MAX_L - LEN_W'(1));
        wr_fire  = byte_fire && store && word_end;
        wr_word  = acc_q | (32'(byte_in) << {len_q[1:0], 3'b000});
        wr_off   = {len_q[LEN_W-1:2], 2'b00};
        len      = len_q;
        too_long = len_q > MAX_L;
    end

    // Accumulate partial words and count frame bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len_q <= '0;
            acc_q <= '0;
        end else if (byte_fire) begin
            len_q <= len_q + LEN_W'(1);
            if (store) acc_q <= wr_fire ? 32'd0 : wr_word;
        end
    end

    // R9: counter advances by one per accepted byte
    a_r9_len_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && !clr) |=> (len_q == $past(len_q) + LEN_W'(1)));
    // R9: nothing beyond the maximum is stored in short mode
    a_r9_no_store_past_max: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_ok && len_q >= MAX_L) |-> !wr_fire);
endmodule

// File: rtl/rxdw_sat_count.sv
// Saturating event counter; holds at its maximum value.
module rxdw_sat_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count increments, never wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (inc && ~&count)     count <= count + W'(1);
    end

    // R6: counter never goes backwards
    a_r6_miss_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count >= $past(count)));
endmodule

// File: rtl/rxdw_ctrl.sv
// Chain walker: fetches a record, checks ownership, routes payload writes,
// writes status back and follows the link. Memory read data is assumed to
// arrive one cycle after the request; writes complete in the request cycle.
module rxdw_ctrl
    import rxdw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int CRC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              long_ok,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] list_start,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              pk_clr,
    output logic              pk_fire,
    input  logic              pk_wr_fire,
    input  logic [31:0]       pk_wr_word,
    input  logic [LEN_W-1:0]  pk_wr_off,
    input  logic [LEN_W-1:0]  pk_len,
    input  logic              pk_too_long,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              ev_done,
    output logic              ev_unavail,
    output logic              miss_inc
);
    rx_state_t         state_q;
    logic [ADDR_W-1:0] ptr_q, buf_q, next_q;
    logic [31:0]       status_q;
    logic              owned;
    logic              fire;
    logic [15:0]       rep_len;

    // Derived handshake and ownership decode.
    always_comb begin
        owned    = status_q[31:30] == OWNER_MAC;
        in_ready = (state_q == S_DATA) || (state_q == S_DROP);
        fire     = in_valid && in_ready;
        pk_fire  = fire && (state_q == S_DATA);
        pk_clr   = state_q == S_IDLE;
        rep_len  = 16'(pk_len) + 16'(CRC_BYTES);
        cur_desc = ptr_q;
        ev_done    = state_q == S_WB;
        ev_unavail = (state_q == S_CHK) && !owned;
        miss_inc   = (state_q == S_DROP) && fire && in_last;
    end

    // Memory port multiplexing per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = pk_wr_word;
        unique case (state_q)
            S_RD_ST:  mem_req = 1'b1;
            S_RD_BUF: begin mem_req = 1'b1; mem_addr = ptr_q + ADDR_W'(4);  end
            S_RD_NXT: begin mem_req = 1'b1; mem_addr = ptr_q + ADDR_W'(12); end
            S_DATA: begin
                mem_req  = pk_wr_fire;
                mem_we   = 1'b1;
                mem_addr = buf_q + ADDR_W'(pk_wr_off);
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = make_status(!(pk_too_long && !long_ok), pk_too_long, irq_en, rep_len);
            end
            default: ;
        endcase
    end

    // Sequence the record fetch, payload phase and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            ptr_q    <= '0;
            buf_q    <= '0;
            next_q   <= '0;
            status_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (!rx_en)        ptr_q   <= list_start;
                    else if (in_valid) state_q <= S_RD_ST;
                end
                S_RD_ST:  state_q <= S_RD_BUF;
                S_RD_BUF: begin status_q <= mem_rdata; state_q <= S_RD_NXT; end
                S_RD_NXT: begin buf_q <= mem_rdata[ADDR_W-1:0]; state_q <= S_CHK; end
                S_CHK: begin
                    next_q  <= mem_rdata[ADDR_W-1:0];
                    state_q <= owned ? S_DATA : S_DROP;
                end
                S_DATA: if (fire && in_last) state_q <= S_WB;
                S_DROP: if (fire && in_last) state_q <= S_IDLE;
                S_WB: begin ptr_q <= next_q; state_q <= S_IDLE; end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R7: nothing accepted or accessed while idle and disabled
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !rx_en) |-> (!in_ready && !mem_req));
    // R6: a dropped frame never touches memory
    a_r6_drop_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DROP) |-> !mem_req);
    // R5: pointer moves only at write-back or while disabled
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_WB && !(state_q == S_IDLE && !rx_en)) |=> $stable(ptr_q));
    // R11: completion is a single-cycle pulse, never with unavailable
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !ev_done);
    a_r11_events_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_done, ev_unavail}));
endmodule

// File: rtl/rx_desc_writer.sv
// Receive descriptor chain writer top: wires the chain walker, the byte
// packer and the missed-frame counter. Assumes ADDR_W > LEN_W.
module rx_desc_writer #(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 1518,
    parameter int LEN_W     = 16,
    parameter int MISS_W    = 16,
    parameter int CRC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              long_ok,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] list_start,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              ev_done,
    output logic              ev_unavail,
    output logic [MISS_W-1:0] miss_count
);
    logic             pk_clr, pk_fire, pk_wr_fire, pk_too_long, miss_inc;
    logic [31:0]      pk_wr_word;
    logic [LEN_W-1:0] pk_wr_off, pk_len;

    rxdw_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CRC_BYTES(CRC_BYTES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .long_ok(long_ok), .irq_en(irq_en),
        .list_start(list_start), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .pk_clr(pk_clr), .pk_fire(pk_fire), .pk_wr_fire(pk_wr_fire), .pk_wr_word(pk_wr_word),
        .pk_wr_off(pk_wr_off), .pk_len(pk_len), .pk_too_long(pk_too_long),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cur_desc(cur_desc), .ev_done(ev_done),
        .ev_unavail(ev_unavail), .miss_inc(miss_inc)
    );

    rxdw_packer #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) packer_i (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .byte_fire(pk_fire), .byte_in(in_data),
        .last_in(in_last), .long_ok(long_ok), .wr_fire(pk_wr_fire), .wr_word(pk_wr_word),
        .wr_off(pk_wr_off), .len(pk_len), .too_long(pk_too_long)
    );

    rxdw_sat_count #(.W(MISS_W)) miss_i (
        .clk(clk), .rst_n(rst_n), .inc(miss_inc), .count(miss_count)
    );
endmodule

// File: tb/rx_desc_writer_tb_top.sv
module rx_desc_writer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, long_ok = 1'b0, irq_en = 1'b0;
    logic [31:0] list_start = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, mem_req, mem_we, ev_done, ev_unavail;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_desc;
    logic [15:0] miss_count;

    int checks = 0, errors = 0, cycles = 0;
    int n_done = 0, n_unavail = 0, n_writes = 0, n_req = 0, n_ready = 0;

    logic [31:0] ram [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;

    always #4 clk = ~clk;

    rx_desc_writer dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .long_ok(long_ok), .irq_en(irq_en),
        .list_start(list_start), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cur_desc(cur_desc),
        .ev_done(ev_done), .ev_unavail(ev_unavail), .miss_count(miss_count)
    );

    // Memory model: one-cycle read latency, bench pokes share the write port.
    always @(posedge clk) begin
        if (tb_we) ram[tb_wa] <= tb_wd;
        else if (mem_req && mem_we) ram[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[11:2]];
    end

    // Falling-edge monitor for pulses and traffic.
    always @(negedge clk) begin
        cycles++;
        if (ev_done) n_done++;
        if (ev_unavail) n_unavail++;
        if (mem_req && mem_we) n_writes++;
        if (mem_req) n_req++;
        if (in_ready) n_ready++;
    end

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        finish_up();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = 10'(idx); tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [31:0] ew(input logic [7:0] seed, input int first, input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (first + k < n) w[8*k +: 8] = seed + 8'(first + k);
        return w;
    endfunction

    // Drive one frame byte by byte; returns two falling edges after the last byte.
    task automatic send_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 8'(i); in_last = (i == n - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 in_ready", 32'(in_ready), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 miss_count", 32'(miss_count), 0);
        check("R1 events", {30'd0, ev_done, ev_unavail}, 0);
        check("R1 cur_desc", cur_desc, list_start);
    endtask

    task automatic t_disabled();
        int r0 = n_req, y0 = n_ready;
        list_start = 32'h40;
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h5A;
        repeat (10) @(negedge clk);
        in_valid = 1'b0;
        check("R7 no ready", 32'(n_ready - y0), 0);
        check("R7 no mem", 32'(n_req - r0), 0);
        check("R7 follows start", cur_desc, 32'h40);
        list_start = 32'h0;
        @(negedge clk); @(negedge clk);
        check("R7 follows start 0", cur_desc, 32'h0);
    endtask

    task automatic t_small();
        int d0 = n_done;
        send_frame(7, 8'h11);
        check("R2 word0", ram[32'h40], 32'h14131211);
        check("R2 zero fill", ram[32'h41], 32'h00171615);
        check("R2 guard", ram[32'h42], 32'hDEADBEEF);
        check("R3 status", ram[0], 32'h0010000B);
        check("R5 next ptr", cur_desc, 32'h10);
        check("R11 one done", 32'(n_done - d0), 1);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        send_frame(64, 8'hA0);
        irq_en = 1'b0;
        check("R2 first word", ram[32'h200], ew(8'hA0, 0, 64));
        check("R2 last word", ram[32'h20F], ew(8'hA0, 60, 64));
        check("R4 irq flag", ram[4], 32'h00110044);
        check("R5 next ptr", cur_desc, 32'h20);
    endtask

    task automatic t_unavail();
        int u0 = n_unavail, w0 = n_writes, d0 = n_done;
        send_frame(10, 8'h01);
        check("R6 miss 00", 32'(miss_count), 1);
        check("R6 unavail pulse", 32'(n_unavail - u0), 1);
        check("R6 no writes", 32'(n_writes - w0), 0);
        check("R6 ptr held", cur_desc, 32'h20);
        check("R6 status kept", ram[8], 32'h00001234);
        poke(8, 32'hC000_0000);
        w0 = n_writes;
        send_frame(5, 8'h02);
        check("R6 miss 11", 32'(miss_count), 2);
        check("R6 status kept 11", ram[8], 32'hC000_0000);
        poke(8, 32'h4000_0000);
        send_frame(3, 8'h03);
        check("R6 miss 01", 32'(miss_count), 3);
        check("R6 no writes all", 32'(n_writes - w0), 0);
        check("R6 no done", 32'(n_done - d0), 0);
        check("R6 unavail total", 32'(n_unavail - u0), 3);
        poke(8, 32'h8000_0000);
    endtask

    task automatic t_long();
        long_ok = 1'b1;
        send_frame(1600, 8'h33);
        check("R8 status", ram[8], 32'h00180644);
        check("R8 mid word", ram[32'h40 + 200], ew(8'h33, 800, 1600));
        check("R8 last word", ram[32'h40 + 399], ew(8'h33, 1596, 1600));
        check("R5 wrap ptr", cur_desc, 32'h0);
        long_ok = 1'b0;
    endtask

    task automatic t_trunc();
        poke(0, 32'h8000_0000);
        poke(32'h40 + 380, 32'hDEADBEEF);
        send_frame(1600, 8'h55);
        check("R9 status", ram[0], 32'h00080644);
        check("R9 boundary word", ram[32'h40 + 379], ew(8'h55, 1516, 1518));
        check("R9 beyond untouched", ram[32'h40 + 380], 32'hDEADBEEF);
        check("R9 early word", ram[32'h40 + 5], ew(8'h55, 20, 1518));
        check("R5 ptr", cur_desc, 32'h10);
    endtask

    task automatic t_exact();
        poke(4, 32'h8000_0000);
        send_frame(1518, 8'h77);
        check("R10 status", ram[4], 32'h001005F2);
        check("R10 last word", ram[32'h200 + 379], ew(8'h77, 1516, 1518));
        check("R5 ptr", cur_desc, 32'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        poke(0, 32'h8000_0000); poke(1, 32'h100); poke(3, 32'h010);
        poke(4, 32'h8000_0000); poke(5, 32'h800); poke(7, 32'h020);
        poke(8, 32'h0000_1234); poke(9, 32'h100); poke(11, 32'h000);
        poke(32'h42, 32'hDEADBEEF);
        t_disabled();
        rx_en = 1'b1;
        @(negedge clk);
        t_small();
        t_irq();
        t_unavail();
        t_long();
        t_trunc();
        t_exact();
        finish_up();
    end
endmodule